// File: doc/BRIEF.md
# Memory-Mapped GCD Accelerator

This peripheral computes the greatest common divisor of two unsigned operands on behalf of software. A program stores the first operand, then stores the second. Storing the second operand is what launches the calculation. The program then polls a status word until the result-valid flag appears, and reads the answer. The answer is also latched in a result register. A `busy` pin is brought out so that the chip top can observe the engine while it works.

The bus side is a request/response stream. A request is taken when `req_valid` and `req_ready` are both high on a clock edge. Its response appears on the next cycle. It is held, with `rsp_rdata` stable, until `rsp_ready` is high on an edge. The block keeps at most one response outstanding, so back-pressure on the response channel holds `req_ready` low. The register window sits at parameter `BASE_ADDR` and spans `SPAN_BYTES` bytes. Registers are one `DATA_W`-bit word apart.

Top module: `gcd_mmio`

## Requirements
- R1: After reset the following all hold. `busy` is 0. `rsp_valid` is 0 and `req_ready` is 1. The status, first-operand, second-operand and result registers all read as zero.
- R2: Acceptance and response follow these rules.
  - A request is accepted on an edge where `req_valid` and `req_ready` are both 1.
  - `rsp_valid` is 1 in the cycle after acceptance.
  - `rsp_valid` and `rsp_rdata` stay unchanged until an edge with `rsp_ready` high.
  - `req_ready` is 0 while a response is pending.
  - Write responses carry zero data.
- R3: A write to offset 0x04 stores the first operand, and a read of 0x04 returns it. Writing 0x04 never starts a computation, and it does not disturb one that is running.
- R4: A write to offset 0x08 while idle starts a computation. It clears the result-valid flag. If both operands are nonzero, `busy` is 1 from the next cycle.
- R5: The engine holds a pair (x, y), loaded with (first operand, written value) at the starting edge. On each busy cycle it does one of three things:
  - If y = 0, it finishes.
  - Otherwise, if x < y, it swaps x and y.
  - Otherwise, it replaces x with x − y.
  - `busy` therefore lasts exactly one cycle more than the number of swap or subtract steps.
- R6: On the edge that ends a computation, three things happen together:
  - the result register at offset 0x0C is loaded with the greatest common divisor;
  - the result-valid flag is set;
  - `busy` falls.
- R7: If either operand is zero at the starting edge, the result is loaded on that same edge and the valid flag is set. The result is the other operand, or 0 when both are zero. `busy` never rises.
- R8: A write to offset 0x08 while `busy` is 1 is acknowledged but ignored. The running computation is not restarted, and a read of 0x08 still returns the operand that started it.
- R9: Reads of unmapped offsets in the window (0x10 and up) return zero. So do reads of addresses outside the window. Writes to those addresses, to status (0x00) and to the result (0x0C) change nothing.
- R10: The status word at offset 0x00 carries result-valid in bit 0, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | DATA_W | Read data (zero for writes) |
| busy | output | 1 | Engine is iterating |

## Verification
Several properties are checked on every cycle:
- response data and valid are held under back-pressure;
- a nonzero start raises `busy` with the valid flag cleared;
- `busy` persists while y is nonzero, and the valid flag follows the final step;
- a zero-operand start leaves `busy` low;
- a second-operand write during `busy` leaves the stored operand alone.

Only the bench scenarios can show the rest:
- that the loaded result is the true divisor;
- that `busy` lasts exactly the predicted number of cycles for each operand pair;
- that a dropped restart leaves the original answer intact;
- that unmapped and read-only addresses stay inert.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  typedef enum logic [2:0] {
    SEL_STATUS,
    SEL_OPX,
    SEL_OPY,
    SEL_RESULT,
    SEL_NONE
  } reg_sel_e;

  // word indices inside the register window
  localparam int unsigned IDX_STATUS = 0;
  localparam int unsigned IDX_OPX    = 1;
  localparam int unsigned IDX_OPY    = 2;
  localparam int unsigned IDX_RESULT = 3;
endpackage

// File: rtl/gcd_addr_decode.sv
module gcd_addr_decode
  import gcd_pkg::*;
#(
  parameter int unsigned          ADDR_W     = 16,
  parameter int unsigned          DATA_W     = 32,
  parameter logic [ADDR_W-1:0]    BASE_ADDR  = 16'h0100,
  parameter int unsigned          SPAN_BYTES = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  localparam int unsigned WORD_LSB = $clog2(DATA_W / 8);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] word;
  logic              hit;

  assign off  = addr_i - BASE_ADDR;
  assign word = off >> WORD_LSB;
  assign hit  = (addr_i >= BASE_ADDR) && (off < ADDR_W'(SPAN_BYTES));

  always_comb begin
    sel_o = SEL_NONE;
    if (hit) begin
      if (word == ADDR_W'(IDX_STATUS))      sel_o = SEL_STATUS;
      else if (word == ADDR_W'(IDX_OPX))    sel_o = SEL_OPX;
      else if (word == ADDR_W'(IDX_OPY))    sel_o = SEL_OPY;
      else if (word == ADDR_W'(IDX_RESULT)) sel_o = SEL_RESULT;
    end
  end
endmodule

// File: rtl/gcd_step_engine.sv
module gcd_step_engine #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  logic [W-1:0] x_q, y_q;
  logic         busy_q;
  logic         launch, zero_op;

  assign launch   = start_i && !busy_q;
  assign zero_op  = (a_i == '0) || (b_i == '0);
  assign done_o   = (launch && zero_op) || (busy_q && (y_q == '0));
  assign result_o = busy_q ? x_q : (a_i | b_i);
  assign busy_o   = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      busy_q <= 1'b0;
    end else if (launch && !zero_op) begin
      x_q    <= a_i;
      y_q    <= b_i;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (y_q == '0) begin
        busy_q <= 1'b0;
      end else if (x_q < y_q) begin
        x_q <= y_q;
        y_q <= x_q;
      end else begin
        x_q <= x_q - y_q;
      end
    end
  end

  // R5: iteration continues while the second term is nonzero
  a_r5_keep_busy : assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && (y_q != '0) |=> busy_q);

  // R6: finishing step drops busy
  a_r6_finish_drops : assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && (y_q == '0) |=> !busy_q);

  // R7: zero operand never enters the busy state
  a_r7_zero_no_busy : assert property (@(posedge clk) disable iff (!rst_n)
    launch && zero_op |=> !busy_q);
endmodule

// File: rtl/gcd_reg_bank.sv
module gcd_reg_bank
  import gcd_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 16,
  parameter int unsigned       DATA_W     = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 16'h0100,
  parameter int unsigned       SPAN_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              start_o,
  output logic [DATA_W-1:0] op_a_o,
  output logic [DATA_W-1:0] op_b_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] result_i
);
  reg_sel_e          sel;
  logic              accept, wr_x, wr_y;
  logic [DATA_W-1:0] x_q, y_q, res_q, rd_mux, rsp_data_q;
  logic              valid_q, rsp_valid_q;

  gcd_addr_decode #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BASE_ADDR (BASE_ADDR),
    .SPAN_BYTES(SPAN_BYTES)
  ) u_decode (
    .addr_i(req_addr_i),
    .sel_o (sel)
  );

  assign req_ready_o = !rsp_valid_q;
  assign accept      = req_valid_i && !rsp_valid_q;
  assign wr_x        = accept && req_write_i && (sel == SEL_OPX);
  assign wr_y        = accept && req_write_i && (sel == SEL_OPY);
  assign start_o     = wr_y && !busy_i;
  assign op_a_o      = x_q;
  assign op_b_o      = req_wdata_i;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_data_q;

  always_comb begin
    unique case (sel)
      SEL_STATUS: rd_mux = {{(DATA_W-1){1'b0}}, valid_q};
      SEL_OPX:    rd_mux = x_q;
      SEL_OPY:    rd_mux = y_q;
      SEL_RESULT: rd_mux = res_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= req_write_i ? '0 : rd_mux;
    end else if (rsp_valid_q && rsp_ready_i) begin
      rsp_valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q     <= '0;
      y_q     <= '0;
      res_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (wr_x)    x_q <= req_wdata_i;
      if (start_o) y_q <= req_wdata_i;
      if (done_i) begin
        res_q   <= result_i;
        valid_q <= 1'b1;
      end else if (start_o) begin
        valid_q <= 1'b0;
      end
    end
  end

  // R2: a stalled response holds its data
  a_r2_rsp_hold : assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_q && !rsp_ready_i |=> rsp_valid_q && $stable(rsp_data_q));

  // R4: a nonzero start clears the flag and raises busy
  a_r4_start_clears : assert property (@(posedge clk) disable iff (!rst_n)
    start_o && !done_i |=> !valid_q && busy_i);

  // R6: completion from the engine sets the flag
  a_r6_done_sets_valid : assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> valid_q);

  // R8: second-operand write during busy leaves the register alone
  a_r8_busy_write_ignored : assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && wr_y |=> $stable(y_q));
endmodule

// File: rtl/gcd_mmio.sv
module gcd_mmio #(
  parameter int unsigned       ADDR_W     = 16,
  parameter int unsigned       DATA_W     = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 16'h0100,
  parameter int unsigned       SPAN_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              busy
);
  logic              start, done;
  logic [DATA_W-1:0] op_a, op_b, result;

  gcd_reg_bank #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BASE_ADDR (BASE_ADDR),
    .SPAN_BYTES(SPAN_BYTES)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid_i(req_valid),
    .req_ready_o(req_ready),
    .req_write_i(req_write),
    .req_addr_i (req_addr),
    .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid),
    .rsp_ready_i(rsp_ready),
    .rsp_rdata_o(rsp_rdata),
    .start_o    (start),
    .op_a_o     (op_a),
    .op_b_o     (op_b),
    .busy_i     (busy),
    .done_i     (done),
    .result_i   (result)
  );

  gcd_step_engine #(
    .W(DATA_W)
  ) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .a_i     (op_a),
    .b_i     (op_b),
    .busy_o  (busy),
    .done_o  (done),
    .result_o(result)
  );
endmodule

// File: tb/gcd_mmio_tb_top.sv
`timescale 1ns/1ps
module gcd_mmio_tb_top;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 32;
  localparam logic [15:0] BASE   = 16'h0100;
  localparam int unsigned SPAN   = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rsp_ready = 1'b0;
  logic              req_ready, rsp_valid, busy;
  logic [DATA_W-1:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_acc_cyc = -1;
  int ncyc = 0;

  always #2 clk = ~clk;

  gcd_mmio #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE), .SPAN_BYTES(SPAN)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .busy(busy)
  );

  // ---------------- reference model ----------------
  logic [31:0] mx = 0, my = 0, mres = 0, mgcd = 0;
  logic        mvalid = 0, mbusy = 0;
  int unsigned mrem = 0;
  logic        rdy_s = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  function automatic int unsigned steps(logic [31:0] a, logic [31:0] b);
    logic [31:0] x = a, y = b, t;
    int unsigned k = 0;
    while (y != 0) begin
      if (x < y) begin t = x; x = y; y = t; end
      else x = x - y;
      k++;
    end
    return k + 1;
  endfunction

  function automatic logic [31:0] gcd_ref(logic [31:0] a, logic [31:0] b);
    logic [31:0] p = a, q = b, r;
    while (q != 0) begin r = p % q; p = q; q = r; end
    return p;
  endfunction

  function automatic int word_of(logic [15:0] addr);
    if (addr < BASE || (addr - BASE) >= SPAN) return -1;
    return int'((addr - BASE) >> 2);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic old;
    int   w;
    if (!rst_n) begin
      mx = 0; my = 0; mres = 0; mvalid = 0; mbusy = 0; mrem = 0;
    end else begin
      cyc++;
      w = word_of(req_addr);
      old = mbusy;
      if (rdy_s && req_valid) begin
        last_acc_cyc = cyc;
        if (req_write) begin
          exp_q.push_back(0); tag_q.push_back("R2 write rsp");
        end else begin
          case (w)
            0: begin exp_q.push_back({31'b0, mvalid}); tag_q.push_back("R10 status"); end
            1: begin exp_q.push_back(mx); tag_q.push_back("R3 opx"); end
            2: begin exp_q.push_back(my); tag_q.push_back("R8 opy"); end
            3: begin exp_q.push_back(mres); tag_q.push_back("R6 result"); end
            default: begin exp_q.push_back(0); tag_q.push_back("R9 unmapped"); end
          endcase
        end
      end
      if (old) begin
        mrem--;
        if (mrem == 0) begin mbusy = 0; mvalid = 1; mres = mgcd; end
      end
      if (rdy_s && req_valid && req_write) begin
        if (w == 1) mx = req_wdata;
        else if (w == 2 && !old) begin
          my = req_wdata;
          if (mx == 0 || req_wdata == 0) begin
            mres = mx | req_wdata; mvalid = 1;
          end else begin
            mbusy = 1; mvalid = 0;
            mrem = steps(mx, req_wdata);
            mgcd = gcd_ref(mx, req_wdata);
          end
        end
      end
    end
  end

  // ---------------- negedge monitor ----------------
  logic        prev_valid = 0, prev_taken = 0;
  logic [31:0] prev_data = 0;

  always @(negedge clk) begin
    logic taken;
    ncyc++;
    rsp_ready = (ncyc % 4) != 1;
    rdy_s = req_ready;
    if (rst_n && cyc > 0) begin
      check("R4/R5/R7/R8 busy", {31'b0, busy}, {31'b0, mbusy});
      if (last_acc_cyc == cyc) check("R2 rsp next cycle", {31'b0, rsp_valid}, 1);
      if (rsp_valid) check("R2 ready low while pending", {31'b0, req_ready}, 0);
      if (rsp_valid && prev_valid && !prev_taken) check("R2 data stable", rsp_rdata, prev_data);
      taken = rsp_valid && rsp_ready;
      if (taken) begin
        if (exp_q.size() == 0) check("R2 unexpected rsp", 1, 0);
        else check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
      prev_valid = rsp_valid; prev_taken = taken; prev_data = rsp_rdata;
    end
  end

  // ---------------- stimulus ----------------
  task automatic bus(logic wr, logic [15:0] addr, logic [31:0] data);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = addr; req_wdata = data;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || rsp_valid) @(negedge clk);
  endtask

  task automatic run(logic [31:0] a, logic [31:0] b);
    bus(1, BASE + 16'h4, a);
    bus(1, BASE + 16'h8, b);
    bus(0, BASE + 16'h0, 0);
    while (mbusy) @(negedge clk);
    bus(0, BASE + 16'h0, 0);
    bus(0, BASE + 16'hC, 0);
    bus(0, BASE + 16'h4, 0);
    bus(0, BASE + 16'h8, 0);
    drain();
    check("R6 result vs gcd", mres, gcd_ref(a, b));
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 busy", {31'b0, busy}, 0);
    check("R1 rsp_valid", {31'b0, rsp_valid}, 0);
    check("R1 req_ready", {31'b0, req_ready}, 1);
    bus(0, BASE + 16'h0, 0);
    bus(0, BASE + 16'h4, 0);
    bus(0, BASE + 16'h8, 0);
    bus(0, BASE + 16'hC, 0);
    drain();

    run(48, 18);
    run(17, 5);
    run(100, 100);
    run(1071, 462);
    run(32'h8000_0000, 32'h0001_0000);
    run(0, 7);
    run(9, 0);
    run(0, 0);
    run(1, 1500);

    // R8: restart attempt while busy; R3: x write during busy has no effect
    bus(1, BASE + 16'h4, 3000);
    bus(1, BASE + 16'h8, 7);
    bus(1, BASE + 16'h8, 5);
    bus(1, BASE + 16'h4, 9999);
    bus(0, BASE + 16'h8, 0);
    bus(0, BASE + 16'h4, 0);
    while (mbusy) @(negedge clk);
    bus(0, BASE + 16'hC, 0);
    drain();
    check("R8 result of original operands", mres, 1);

    // R9: unmapped, outside window, read-only registers
    bus(1, BASE + 16'h14, 32'hFFFF_FFFF);
    bus(1, BASE + 16'h0, 32'hFFFF_FFFF);
    bus(1, BASE + 16'hC, 32'hDEAD_BEEF);
    bus(1, BASE - 16'h4, 32'h1234_5678);
    bus(0, BASE + 16'h10, 0);
    bus(0, BASE + 16'h14, 0);
    bus(0, BASE + 16'h1C, 0);
    bus(0, BASE - 16'h4, 0);
    bus(0, BASE + 16'h40, 0);
    bus(0, BASE + 16'h0, 0);
    bus(0, BASE + 16'hC, 0);
    drain();
    repeat (4) @(negedge clk);
    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end
endmodule